// File: doc/BRIEF.md
# Segment Register Loader with Descriptor Cache

This block keeps six segment registers, each pairing a 16-bit selector with a decoded copy of the descriptor it names. A load request gives a register number and a selector. The block splits the selector into an index, a table choice and a requested privilege level. It bounds-checks the index against the chosen table's limit and forms the descriptor's byte address from that table's base. It then reads the 8-byte descriptor as two 32-bit words.

After the fetch, the block checks the descriptor's class, type, privilege and presence against the target register. If the accessed flag is clear, it writes the upper word back with that flag set. Only then does it commit the decoded base, limit and attributes into the register's cache. Each load ends with a one-cycle `done` pulse or a one-cycle `fault` pulse with a code. A read port shows any cached register. The current privilege level is the requested level held in the code register's selector.

Load requests use a valid/ready handshake. `ld_ready` is high only while the block is idle, and a request is taken on a clock edge where `ld_valid` and `ld_ready` are both high. The memory port is a request/ready handshake. The block holds `mem_req_valid`, address, write enable and write data steady until `mem_req_ready` is seen. Read data is captured in the cycle where both are high.

Top module: `seg_loader`

## Requirements
- R1: After reset all six registers read back with valid 0, selector 0, base 0 and limit 0; `cpl` is 0; `ld_ready` is 1 and `mem_req_valid` is 0.
- R2: Register numbers 0 to 5 select the code, stack, and four data registers in that order; a load naming 6 or 7 ends with fault code 1 and no memory access.
- R3: Selector bits 1:0 are the requested level, bit 2 picks the local table when 1 and the global table when 0, and bits 15:3 are the index; the descriptor's low word is read at table base + index×8 and its high word at that address + 4.
- R4: When index×8+7 exceeds the chosen table's limit, the load ends with fault code 3 and no memory access.
- R5: A selector with index 0 and table bit 0 loaded into registers 2 to 5 completes with `done`, stores the selector with valid 0, and makes no memory access; loading it into register 0 or 1 gives fault code 2.
- R6: A descriptor whose class flag (bit 44) is 0 gives fault code 4.
- R7: Type bits are descriptor bits 43:40 (bit 3 code, bit 2 conforming for code, bit 1 writable for data or readable for code). The code register needs a code segment, the stack register a writable data segment, and the data registers a data or readable code segment; otherwise the load ends with fault code 5.
- R8: Code register: DPL equal to RPL, or DPL ≤ RPL if conforming. Stack register: DPL equal to both RPL and `cpl`. Data registers: DPL ≥ max(`cpl`, RPL) unless conforming code. A violation gives fault code 6.
- R9: A descriptor with the present flag (bit 47) clear gives fault code 7, checked after codes 4 to 6.
- R10: If the accessed flag (bit 40) is 0, the high word is written back with bit 8 set at base + index×8 + 4 before commit; if it is 1, no write occurs.
- R11: On commit the register holds base from bits 63:56, 39:32 and 31:16, and a limit from bits 51:48 and 15:0. The limit is scaled to (raw<<12)|0xFFF when bit 55 is set. The register also holds the type with the accessed bit set, DPL, bit 54, and valid 1. `cpl` equals bits 1:0 of the code register's selector.
- R12: A faulting load leaves the target register unchanged; `done` and `fault` are single-cycle and never high together.
- R13: While a memory request waits for `mem_req_ready`, its address, write enable and data stay stable, and `ld_ready` is low from acceptance until the load's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Block idle, request may be taken |
| ld_reg | input | 3 | Target register number |
| ld_sel | input | 16 | Selector to load |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table limit (last valid byte) |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 16 | Local table limit (last valid byte) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request / read data valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | Load completed (one cycle) |
| fault | output | 1 | Load faulted (one cycle) |
| fault_code | output | 3 | Fault reason, valid with `fault` |
| rd_reg | input | 3 | Read port register number |
| rd_sel | output | 16 | Cached selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 32 | Cached byte-granular limit |
| rd_type | output | 4 | Cached type field |
| rd_dpl | output | 2 | Cached DPL |
| rd_db | output | 1 | Cached default-size flag |
| rd_valid | output | 1 | Register holds a usable descriptor |
| cpl | output | 2 | Current privilege level |

## Verification
The accessed-flag write-back and the commit of the cache share one clock edge: the write handshake's completing edge also updates the register and raises `done`. The bench provokes this with a descriptor whose accessed flag is clear while the memory model stalls every other cycle. It then judges that `done` appears only after the write was taken, that the stored word gained bit 8, and that the read port shows the new contents at that point and not before. A second overlap is a null selector, which is accepted and committed on the same edge; the bench checks that `done` follows immediately with no memory traffic.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_NUM  = 6;
  localparam int SEG_IW   = 3;
  localparam int SEL_W    = 16;
  localparam int ADDR_W   = 32;
  localparam int SEG_CODE = 0;
  localparam int SEG_STK  = 1;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_REG    = 3'd1,
    FLT_NULL   = 3'd2,
    FLT_LIMIT  = 3'd3,
    FLT_SYS    = 3'd4,
    FLT_TYPE   = 3'd5,
    FLT_PRIV   = 3'd6,
    FLT_ABSENT = 3'd7
  } seg_fault_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [3:0]        typ;
    logic [1:0]        dpl;
    logic              db;
    logic              valid;
  } seg_entry_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [SEG_IW-1:0] reg_idx,
  input  logic [AW-1:0]     gdt_base,
  input  logic [LW-1:0]     gdt_limit,
  input  logic [AW-1:0]     ldt_base,
  input  logic [LW-1:0]     ldt_limit,
  output logic [AW-1:0]     desc_addr,
  output logic              is_null,
  output seg_fault_e        early_fault
);
  localparam int IXW = SEL_W - 3;

  logic [IXW-1:0] index;
  logic           use_local;
  logic [LW:0]    last_byte;
  logic [LW-1:0]  tbl_limit;

  assign index     = sel[SEL_W-1:3];
  assign use_local = sel[2];
  assign tbl_limit = use_local ? ldt_limit : gdt_limit;
  assign last_byte = (LW+1)'({index, 3'b111});
  assign desc_addr = (use_local ? ldt_base : gdt_base) + AW'({index, 3'b000});
  assign is_null   = (index == '0) && !use_local;

  always_comb begin
    if (int'(reg_idx) >= SEG_NUM)
      early_fault = FLT_REG;
    else if (is_null && (int'(reg_idx) == SEG_CODE || int'(reg_idx) == SEG_STK))
      early_fault = FLT_NULL;
    else if (is_null)
      early_fault = FLT_NONE;
    else if (last_byte > {1'b0, tbl_limit})
      early_fault = FLT_LIMIT;
    else
      early_fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_pkg::*;
(
  input  logic [31:0]       lo_word,
  input  logic [31:0]       hi_word,
  input  logic [SEG_IW-1:0] reg_idx,
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        cur_pl,
  output seg_fault_e        chk_fault,
  output seg_entry_t        entry
);
  logic [3:0]  typ;
  logic [1:0]  dpl, rpl, max_pl;
  logic        is_code, conforming, rw_bit, type_ok, priv_ok;
  logic [19:0] raw_lim;

  assign typ        = hi_word[11:8];
  assign dpl        = hi_word[14:13];
  assign rpl        = sel[1:0];
  assign is_code    = typ[3];
  assign conforming = is_code & typ[2];
  assign rw_bit     = typ[1];
  assign max_pl     = (cur_pl > rpl) ? cur_pl : rpl;
  assign raw_lim    = {hi_word[19:16], lo_word[15:0]};

  always_comb begin
    if (int'(reg_idx) == SEG_CODE) begin
      type_ok = is_code;
      priv_ok = conforming ? (dpl <= rpl) : (dpl == rpl);
    end else if (int'(reg_idx) == SEG_STK) begin
      type_ok = !is_code && rw_bit;
      priv_ok = (dpl == rpl) && (dpl == cur_pl);
    end else begin
      type_ok = !is_code || rw_bit;
      priv_ok = conforming || (dpl >= max_pl);
    end
  end

  always_comb begin
    if (!hi_word[12])      chk_fault = FLT_SYS;
    else if (!type_ok)     chk_fault = FLT_TYPE;
    else if (!priv_ok)     chk_fault = FLT_PRIV;
    else if (!hi_word[15]) chk_fault = FLT_ABSENT;
    else                   chk_fault = FLT_NONE;
  end

  always_comb begin
    entry.sel   = sel;
    entry.base  = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    entry.limit = hi_word[23] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
    entry.typ   = typ | 4'b0001;
    entry.dpl   = dpl;
    entry.db    = hi_word[22];
    entry.valid = 1'b1;
  end
endmodule

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_pkg::*;
#(
  parameter int N = SEG_NUM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_IW-1:0] wr_idx,
  input  seg_entry_t        wr_entry,
  input  logic [SEG_IW-1:0] rd_idx,
  output seg_entry_t        rd_entry,
  output logic [1:0]        cur_pl
);
  seg_entry_t slot_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && wr_idx == SEG_IW'(g))
        slot_q[g] <= wr_entry;
    end
  end

  always_comb begin
    rd_entry = '0;
    for (int i = 0; i < N; i++)
      if (rd_idx == SEG_IW'(i)) rd_entry = slot_q[i];
  end

  assign cur_pl = slot_q[SEG_CODE].sel[1:0];
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  output logic        ld_ready,
  input  logic [2:0]  ld_reg,
  input  logic [15:0] ld_sel,
  input  logic [31:0] gdt_base,
  input  logic [15:0] gdt_limit,
  input  logic [31:0] ldt_base,
  input  logic [15:0] ldt_limit,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic [2:0]  fault_code,
  input  logic [2:0]  rd_reg,
  output logic [15:0] rd_sel,
  output logic [31:0] rd_base,
  output logic [31:0] rd_limit,
  output logic [3:0]  rd_type,
  output logic [1:0]  rd_dpl,
  output logic        rd_db,
  output logic        rd_valid,
  output logic [1:0]  cpl
);
  typedef enum logic [2:0] {ST_IDLE, ST_RD_LO, ST_RD_HI, ST_CHECK, ST_WB} st_e;

  st_e               state_q;
  logic [SEG_IW-1:0] reg_q;
  logic [SEL_W-1:0]  sel_q;
  logic [31:0]       addr_q, lo_q, hi_q;
  logic              done_q, fault_q;
  logic [2:0]        code_q;

  logic        accept, dec_null, wr_en;
  logic [31:0] dec_addr;
  seg_fault_e  dec_fault, chk_fault;
  seg_entry_t  chk_entry, wr_entry, rd_entry;
  logic [SEG_IW-1:0] wr_idx;

  seg_sel_decode #(.AW(32), .LW(16)) u_dec (
    .sel(ld_sel), .reg_idx(ld_reg),
    .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .ldt_base(ldt_base), .ldt_limit(ldt_limit),
    .desc_addr(dec_addr), .is_null(dec_null), .early_fault(dec_fault)
  );

  seg_desc_check u_chk (
    .lo_word(lo_q), .hi_word(hi_q), .reg_idx(reg_q), .sel(sel_q),
    .cur_pl(cpl), .chk_fault(chk_fault), .entry(chk_entry)
  );

  assign ld_ready      = (state_q == ST_IDLE);
  assign accept        = ld_valid && ld_ready;
  assign mem_req_valid = (state_q == ST_RD_LO) || (state_q == ST_RD_HI) || (state_q == ST_WB);
  assign mem_we        = (state_q == ST_WB);
  assign mem_addr      = (state_q == ST_RD_LO) ? addr_q : addr_q + 32'd4;
  assign mem_wdata     = hi_q | 32'h0000_0100;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = reg_q;
    wr_entry = chk_entry;
    if (accept && dec_null && dec_fault == FLT_NONE) begin
      wr_en          = 1'b1;
      wr_idx         = ld_reg;
      wr_entry       = '0;
      wr_entry.sel   = ld_sel;
    end else if (state_q == ST_CHECK && chk_fault == FLT_NONE && hi_q[8]) begin
      wr_en = 1'b1;
    end else if (state_q == ST_WB && mem_req_ready) begin
      wr_en = 1'b1;
    end
  end

  seg_reg_file #(.N(SEG_NUM)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_entry(wr_entry), .rd_idx(rd_reg), .rd_entry(rd_entry), .cur_pl(cpl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      reg_q   <= '0;
      sel_q   <= '0;
      addr_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          reg_q  <= ld_reg;
          sel_q  <= ld_sel;
          addr_q <= dec_addr;
          if (dec_fault != FLT_NONE) begin
            fault_q <= 1'b1;
            code_q  <= dec_fault;
          end else if (dec_null) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_req_ready) begin
          lo_q    <= mem_rdata;
          state_q <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_req_ready) begin
          hi_q    <= mem_rdata;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (chk_fault != FLT_NONE) begin
            fault_q <= 1'b1;
            code_q  <= chk_fault;
            state_q <= ST_IDLE;
          end else if (hi_q[8]) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WB;
          end
        end
        ST_WB: if (mem_req_ready) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
  assign rd_sel     = rd_entry.sel;
  assign rd_base    = rd_entry.base;
  assign rd_limit   = rd_entry.limit;
  assign rd_type    = rd_entry.typ;
  assign rd_dpl     = rd_entry.dpl;
  assign rd_db      = rd_entry.db;
  assign rd_valid   = rd_entry.valid;
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        fault,
  input logic [2:0]  fault_code
);
  // R13
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !ld_ready);

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R12
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  fault_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_code != 3'd0);

  // R10
  wb_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> (mem_addr[2:0] == 3'd4 && mem_wdata[8]));

  // R10
  wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we && mem_req_ready) |=> done);
endmodule

bind seg_loader seg_loader_chk u_seg_loader_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .done(done), .fault(fault), .fault_code(fault_code)
);

// File: tb/tb_seg_loader.sv
module tb_seg_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [2:0]  ld_reg = '0;
  logic [15:0] ld_sel = '0;
  logic [31:0] gdt_base = 32'h100;
  logic [15:0] gdt_limit = 16'h003F;
  logic [31:0] ldt_base = 32'h200;
  logic [15:0] ldt_limit = 16'h0017;
  logic        mem_req_valid, mem_req_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, fault;
  logic [2:0]  fault_code;
  logic [2:0]  rd_reg = '0;
  logic [15:0] rd_sel;
  logic [31:0] rd_base, rd_limit;
  logic [3:0]  rd_type;
  logic [1:0]  rd_dpl;
  logic        rd_db, rd_valid;
  logic [1:0]  cpl;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic stall_en = 1'b0;
  logic tgl = 1'b0;
  logic [31:0] mem [256];

  always #5 clk = ~clk;

  seg_loader dut (.*);

  assign mem_req_ready = stall_en ? tgl : 1'b1;
  assign mem_rdata     = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    tgl <= ~tgl;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkd(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] t, input logic s, input logic [1:0] dpl, input logic p, input logic g);
    return {b[31:24], g, 1'b1, 2'b00, l[19:16], p, dpl, s, t, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic put(input logic [31:0] a, input logic [63:0] d);
    mem[a[9:2]]      = d[31:0];
    mem[a[9:2] + 1]  = d[63:32];
  endtask

  logic       got_done;
  logic [2:0] got_code;

  task automatic do_load(input logic [2:0] r, input logic [15:0] s);
    int n;
    @(negedge clk);
    ld_reg = r; ld_sel = s; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    n = 0;
    while (!(done || fault) && n < 200) begin
      @(negedge clk);
      n++;
    end
    got_done = done;
    got_code = fault ? fault_code : 3'd0;
  endtask

  task automatic look(input logic [2:0] r);
    rd_reg = r;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 ld_ready", 32'(ld_ready), 1);
    chk("R1 mem_req_valid", 32'(mem_req_valid), 0);
    chk("R1 cpl", 32'(cpl), 0);
    for (int i = 0; i < 6; i++) begin
      look(3'(i));
      chk("R1 valid", 32'(rd_valid), 0);
      chk("R1 sel/base/limit", {rd_sel, 16'(rd_base | rd_limit)}, 0);
    end
  endtask

  task automatic t_code_load();
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    look(3'd0);
    chk("R11 CS invalid before", 32'(rd_valid), 0);
    do_load(3'd0, 16'h0008);
    chk("R11 CS done", 32'(got_done), 1);
    look(3'd0);
    chk("R11 CS valid", 32'(rd_valid), 1);
    chk("R11 CS limit G", rd_limit, 32'hFFFF_FFFF);
    chk("R11 CS base", rd_base, 32'h0);
    chk("R11 CS type accessed", 32'(rd_type), 32'hB);
    chk("R3 two reads", 32'(rd_cnt - r0), 2);
    chk("R10 one write", 32'(wr_cnt - w0), 1);
    chk("R10 word updated", 32'(mem[(32'h108 + 4) >> 2][8]), 1);
    chk("R11 cpl", 32'(cpl), 0);
  endtask

  task automatic t_local_data();
    int w0 = wr_cnt;
    do_load(3'd2, 16'h0017);
    chk("R3 local DS done", 32'(got_done), 1);
    look(3'd2);
    chk("R3 local base", rd_base, 32'h1234_5678);
    chk("R11 byte limit", rd_limit, 32'h0000_0ABC);
    chk("R11 sel dpl db", {rd_sel, 14'(rd_dpl), rd_db, rd_valid}, {16'h0017, 14'd3, 1'b1, 1'b1});
    chk("R10 no write when accessed", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_limits();
    int r0 = rd_cnt;
    do_load(3'd3, 16'h0040);
    chk("R4 global past limit", 32'(got_code), 3);
    do_load(3'd3, 16'h001C);
    chk("R4 local past limit", 32'(got_code), 3);
    chk("R4 no memory access", 32'(rd_cnt - r0), 0);
    do_load(3'd6, 16'h0008);
    chk("R2 bad register", 32'(got_code), 1);
    do_load(3'd7, 16'h0017);
    chk("R2 bad register 7", 32'(got_code), 1);
    chk("R2 no memory access", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_null();
    int r0;
    do_load(3'd3, 16'h0017);
    look(3'd3);
    chk("R5 ES loaded first", 32'(rd_valid), 1);
    r0 = rd_cnt;
    do_load(3'd3, 16'h0003);
    chk("R5 null into ES done", 32'(got_done), 1);
    look(3'd3);
    chk("R5 null stored invalid", {rd_sel, 15'd0, rd_valid}, {16'h0003, 16'h0000});
    chk("R5 null no access", 32'(rd_cnt - r0), 0);
    do_load(3'd1, 16'h0000);
    chk("R5 null into SS", 32'(got_code), 2);
    do_load(3'd0, 16'h0000);
    chk("R5 null into CS", 32'(got_code), 2);
  endtask

  task automatic t_class_type();
    do_load(3'd2, 16'h0010);
    chk("R6 system segment", 32'(got_code), 4);
    look(3'd2);
    chk("R12 DS unchanged", 32'(rd_sel), 32'h0017);
    do_load(3'd2, 16'h0018);
    chk("R7 exec-only code in DS", 32'(got_code), 5);
    do_load(3'd0, 16'h0028);
    chk("R7 data into CS", 32'(got_code), 5);
    do_load(3'd1, 16'h0020);
    chk("R7 read-only data into SS", 32'(got_code), 5);
    look(3'd1);
    chk("R12 SS unchanged", 32'(rd_valid), 0);
  endtask

  task automatic t_privilege();
    do_load(3'd4, 16'h002B);
    chk("R8 data DPL below RPL", 32'(got_code), 6);
    do_load(3'd1, 16'h0028);
    chk("R8 SS matching levels", 32'(got_done), 1);
    look(3'd1);
    chk("R11 SS base", rd_base, 32'h0000_4000);
    do_load(3'd1, 16'h0031);
    chk("R8 SS RPL/CPL mismatch", 32'(got_code), 6);
    look(3'd1);
    chk("R12 SS kept", 32'(rd_sel), 32'h0028);
    do_load(3'd4, 16'h003B);
    chk("R8 conforming readable code in FS", 32'(got_done), 1);
  endtask

  task automatic t_present();
    do_load(3'd5, 16'h0007);
    chk("R9 not present", 32'(got_code), 7);
    look(3'd5);
    chk("R12 GS unchanged", 32'(rd_valid), 0);
  endtask

  task automatic t_stall_wb();
    int w0 = wr_cnt;
    stall_en = 1'b1;
    look(3'd4);
    do_load(3'd4, 16'h000F);
    chk("R13 done under stall", 32'(got_done), 1);
    chk("R10 write under stall", 32'(wr_cnt - w0), 1);
    chk("R10 accessed set in memory", 32'(mem[(32'h208 + 4) >> 2][8]), 1);
    look(3'd4);
    chk("R11 page-scaled limit", rd_limit, 32'h0001_0FFF);
    chk("R11 base after stall", rd_base, 32'h0000_8000);
    stall_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put(32'h108, mkd(32'h0,        20'hFFFFF, 4'hA, 1'b1, 2'd0, 1'b1, 1'b1));
    put(32'h110, mkd(32'h0,        20'h00067, 4'h9, 1'b0, 2'd0, 1'b1, 1'b0));
    put(32'h118, mkd(32'h0,        20'h00FFF, 4'h9, 1'b1, 2'd0, 1'b1, 1'b0));
    put(32'h120, mkd(32'h0,        20'h00FFF, 4'h0, 1'b1, 2'd0, 1'b1, 1'b0));
    put(32'h128, mkd(32'h4000,     20'h00FFF, 4'h3, 1'b1, 2'd0, 1'b1, 1'b0));
    put(32'h130, mkd(32'h0,        20'h00FFF, 4'h3, 1'b1, 2'd1, 1'b1, 1'b0));
    put(32'h138, mkd(32'h0,        20'h00FFF, 4'hF, 1'b1, 2'd0, 1'b1, 1'b0));
    put(32'h200, mkd(32'h0,        20'h00FFF, 4'h3, 1'b1, 2'd3, 1'b0, 1'b0));
    put(32'h208, mkd(32'h8000,     20'h00010, 4'h2, 1'b1, 2'd3, 1'b1, 1'b1));
    put(32'h210, mkd(32'h12345678, 20'h00ABC, 4'h3, 1'b1, 2'd3, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_code_load();
    t_local_data();
    t_limits();
    t_null();
    t_class_type();
    t_privilege();
    t_present();
    t_stall_wb();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule